// File: doc/BRIEF.md
# NAND Flash Controller Host Register Front-End

This block sits between a host register bus and an 8-bit NAND flash device. The host writes command, address and data bytes into a small shared write buffer. A bus-cycle sequencer drains that buffer in order and turns each entry into one flash cycle. A command entry raises the command latch enable, an address entry raises the address latch enable, and a data entry raises neither. While the flash ready/busy pin is low, the sequencer issues no read cycle.

A single-byte read does not return data on the host read that asks for it. The host writes any value to a read-request register, and the request is queued behind the earlier entries. When the captured byte is ready, a sticky read-ready flag sets and the byte can be read from the read-data register. Interrupt status bits are cleared by writing one to them, and a mask register selects which of them drive the interrupt line.

The host also controls three things outside the buffer. It can raise a page read or page write start strobe for an external page engine. It can start a self-clearing ECC/counter reset. It can set the read and write strobe widths through the control register.

Top module: `nfc_host_frontend`

## Requirements
- R1: After reset, the status register reads 0x11 in bits [4:0] (buffer empty in bit 4, not-busy in bit 0 with the ready pin high), the interrupt status reads 0, and CE#, WE# and RE# are high.
- R2: Writes to the command, address and data-write registers each add one entry to a 4-entry buffer. Status bit 1 is 1 while the buffer holds 4 entries, and status bit 4 is 1 while it holds none.
- R3: A buffer write that arrives while the buffer is full is dropped and never reaches the flash bus. It sets interrupt status bit 1 (overflow).
- R4: Entries are issued in write order. Each write-type cycle holds WE# low for exactly (write delay + 1) clocks, with the byte on `fl_dout` and `fl_doe` high. CLE is high for a command entry and ALE is high for an address entry. One hold clock follows each cycle, and CE# stays low through the cycle. An entry written at clock edge k drops WE# after edge k+1.
- R5: A write of any value to the read-request register queues a read cycle. RE# is held low for (read delay + 1) clocks, and the byte on `fl_din` is captured at the edge that raises RE#. From that edge the byte is readable from the read-data register, and interrupt status bit 3 (read ready) sets one edge later.
- R6: A read cycle at the head of the buffer does not start while the registered ready pin is low, and the entries behind it wait with it.
- R7: Status bit 0 follows `fl_rdy` with one clock of delay. Interrupt status bit 0 sets on each low-to-high change of that registered copy.
- R8: Interrupt status bit 2 (buffer edge) sets when an entry leaves a full buffer.
- R9: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged. A set event in the same clock wins over the clear.
- R10: `irq` is the OR of (interrupt status AND mask), registered one clock after both.
- R11: Page control bit 0 gives a one-clock `pg_rd_go` pulse and sets status bit 3. Page control bit 1 gives a one-clock `pg_wr_go` pulse and sets status bit 2. A `pg_done` pulse clears both pending bits, and if a write was pending it sets interrupt status bit 4.
- R12: Writing bit 0 of the reset register holds `ecc_clr` high for RST_CYCLES clocks. The bit reads back as 1 during that time and then clears by itself. A new request is ignored while one is in progress.
- R13: The control register holds page size in bit 0 (1 = 512 bytes, which drives `cfg_page512`), bus width in bit 1 (stored only), the read delay in [7:4] and the write delay in [11:8].
- R14: A host read returns the addressed register on `host_rdata` one clock after `host_rd`, with no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Register index (0 control, 1 status, 2 interrupt status, 3 mask, 4 command, 5 address, 6 data write, 7 read request, 8 read data, 9 reset, 10 page control) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| irq | output | 1 | Masked interrupt request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dout | output | 8 | Byte driven to flash |
| fl_doe | output | 1 | Output enable for fl_dout |
| fl_din | input | 8 | Byte from flash |
| fl_rdy | input | 1 | Flash ready/busy pin (high = ready) |
| pg_done | input | 1 | Page engine completion pulse |
| pg_rd_go | output | 1 | Page read start pulse |
| pg_wr_go | output | 1 | Page write start pulse |
| ecc_clr | output | 1 | ECC/counter reset, high while in progress |
| cfg_page512 | output | 1 | Page-size configuration |

## Verification
The bench reference model uses the same latency for each result as the requirements state. A host read answers one edge after the request. A buffered entry lowers its strobe on the second edge after its write. A strobe stays low for the delay field plus one clocks. Read-ready status lands one edge after the capturing edge, and `irq` lands one edge after the status and mask. The model advances on each rising edge using only port inputs, and every output is compared one time unit after that edge, so each comparison sees the value due in that cycle. Directed register reads are sampled on the falling edge after the returning edge. They are placed after waits long enough for the slowest strobe width in use.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int AW = 4;
  localparam int HW = 16;
  localparam int NIRQ = 5;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_STAT  = 4'd1;
  localparam logic [AW-1:0] A_ISTAT = 4'd2;
  localparam logic [AW-1:0] A_IMASK = 4'd3;
  localparam logic [AW-1:0] A_CMD   = 4'd4;
  localparam logic [AW-1:0] A_ADDR  = 4'd5;
  localparam logic [AW-1:0] A_DWR   = 4'd6;
  localparam logic [AW-1:0] A_DRD   = 4'd7;
  localparam logic [AW-1:0] A_RDATA = 4'd8;
  localparam logic [AW-1:0] A_RST   = 4'd9;
  localparam logic [AW-1:0] A_PGCTL = 4'd10;

  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2, K_READ = 2'd3} nfc_kind_e;

  typedef struct packed {
    nfc_kind_e  kind;
    logic [7:0] val;
  } nfc_entry_t;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_STROBE = 2'd1, S_HOLD = 2'd2} nfc_seq_e;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  nfc_entry_t din,
  input  logic       pop,
  output nfc_entry_t head,
  output logic       full,
  output logic       empty,
  output logic       drained
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  nfc_entry_t      mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            acc;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign acc     = push && !full;
  assign drained = pop && full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({acc, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_vld,
  input  nfc_entry_t       head,
  input  logic             rdy,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [DLY_W-1:0] rd_dly,
  output logic             pop,
  output logic             fl_ce_n,
  output logic             fl_cle,
  output logic             fl_ale,
  output logic             fl_we_n,
  output logic             fl_re_n,
  output logic [7:0]       fl_dout,
  output logic             fl_doe,
  input  logic [7:0]       fl_din,
  output logic             rd_done,
  output logic [7:0]       rd_byte
);
  nfc_seq_e         st;
  logic [DLY_W-1:0] cnt;
  logic             is_rd;
  logic             head_rd;

  assign head_rd = (head.kind == K_READ);
  assign pop     = (st == S_IDLE) && head_vld && (!head_rd || rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      is_rd   <= 1'b0;
      fl_ce_n <= 1'b1;
      fl_cle  <= 1'b0;
      fl_ale  <= 1'b0;
      fl_we_n <= 1'b1;
      fl_re_n <= 1'b1;
      fl_dout <= '0;
      fl_doe  <= 1'b0;
      rd_done <= 1'b0;
      rd_byte <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pop) begin
            st      <= S_STROBE;
            cnt     <= head_rd ? rd_dly : wr_dly;
            is_rd   <= head_rd;
            fl_ce_n <= 1'b0;
            fl_cle  <= (head.kind == K_CMD);
            fl_ale  <= (head.kind == K_ADDR);
            fl_we_n <= head_rd;
            fl_re_n <= !head_rd;
            fl_dout <= head.val;
            fl_doe  <= !head_rd;
          end
        end
        S_STROBE: begin
          if (cnt == '0) begin
            st      <= S_HOLD;
            fl_we_n <= 1'b1;
            fl_re_n <= 1'b1;
            if (is_rd) begin
              rd_byte <= fl_din;
              rd_done <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          st      <= S_IDLE;
          fl_cle  <= 1'b0;
          fl_ale  <= 1'b0;
          fl_doe  <= 1'b0;
          fl_ce_n <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfc_irq.sv
module nfc_irq
  import nfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] set,
  input  logic            clr_we,
  input  logic [NIRQ-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_bits,
  output logic [NIRQ-1:0] istat,
  output logic [NIRQ-1:0] imask,
  output logic            irq
);
  logic [NIRQ-1:0] clr;

  assign clr = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      istat <= '0;
      imask <= '0;
      irq   <= 1'b0;
    end else begin
      istat <= (istat & ~clr) | set;
      if (mask_we) imask <= mask_bits;
      irq <= |(istat & imask);
    end
  end
endmodule

// File: rtl/nfc_host_frontend.sv
module nfc_host_frontend
  import nfc_pkg::*;
#(
  parameter int WB_DEPTH   = 4,
  parameter int DLY_W      = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          irq,
  output logic          fl_ce_n,
  output logic          fl_cle,
  output logic          fl_ale,
  output logic          fl_we_n,
  output logic          fl_re_n,
  output logic [7:0]    fl_dout,
  output logic          fl_doe,
  input  logic [7:0]    fl_din,
  input  logic          fl_rdy,
  input  logic          pg_done,
  output logic          pg_rd_go,
  output logic          pg_wr_go,
  output logic          ecc_clr,
  output logic          cfg_page512
);
  localparam int RD_LO = 4;
  localparam int WR_LO = RD_LO + DLY_W;
  localparam int RCW   = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYCLES - 1);

  // control fields
  logic             c_psz, c_wide;
  logic [DLY_W-1:0] c_rd_dly, c_wr_dly;

  // ready pin tracking
  logic rdy_q, rdy_qq;

  // write buffer
  logic       wb_push, wb_full, wb_empty, wb_drained, wb_pop;
  nfc_entry_t wb_din, wb_head;

  // sequencer results
  logic       rd_done;
  logic [7:0] rd_byte;

  // page / reset
  logic           pg_rd_pend, pg_wr_pend;
  logic           rst_busy;
  logic [RCW-1:0] rst_cnt;

  // interrupt
  logic [NIRQ-1:0] istat, imask, irq_set;

  logic wr_ctrl, wr_istat, wr_imask, wr_rst, wr_pg;

  assign wr_ctrl  = host_wr && (host_addr == A_CTRL);
  assign wr_istat = host_wr && (host_addr == A_ISTAT);
  assign wr_imask = host_wr && (host_addr == A_IMASK);
  assign wr_rst   = host_wr && (host_addr == A_RST);
  assign wr_pg    = host_wr && (host_addr == A_PGCTL);

  always_comb begin
    wb_push     = 1'b0;
    wb_din.kind = K_DATA;
    wb_din.val  = host_wdata[7:0];
    if (host_wr) begin
      case (host_addr)
        A_CMD:   begin wb_push = 1'b1; wb_din.kind = K_CMD;  end
        A_ADDR:  begin wb_push = 1'b1; wb_din.kind = K_ADDR; end
        A_DWR:   begin wb_push = 1'b1; wb_din.kind = K_DATA; end
        A_DRD:   begin wb_push = 1'b1; wb_din.kind = K_READ; wb_din.val = 8'h00; end
        default: wb_push = 1'b0;
      endcase
    end
  end

  nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk     (clk),
    .rst     (rst),
    .push    (wb_push),
    .din     (wb_din),
    .pop     (wb_pop),
    .head    (wb_head),
    .full    (wb_full),
    .empty   (wb_empty),
    .drained (wb_drained)
  );

  nfc_seq #(.DLY_W(DLY_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .head_vld (!wb_empty),
    .head     (wb_head),
    .rdy      (rdy_q),
    .wr_dly   (c_wr_dly),
    .rd_dly   (c_rd_dly),
    .pop      (wb_pop),
    .fl_ce_n  (fl_ce_n),
    .fl_cle   (fl_cle),
    .fl_ale   (fl_ale),
    .fl_we_n  (fl_we_n),
    .fl_re_n  (fl_re_n),
    .fl_dout  (fl_dout),
    .fl_doe   (fl_doe),
    .fl_din   (fl_din),
    .rd_done  (rd_done),
    .rd_byte  (rd_byte)
  );

  assign irq_set = {pg_done && pg_wr_pend, rd_done, wb_drained,
                    wb_push && wb_full, rdy_q && !rdy_qq};

  nfc_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .set       (irq_set),
    .clr_we    (wr_istat),
    .clr_bits  (host_wdata[NIRQ-1:0]),
    .mask_we   (wr_imask),
    .mask_bits (host_wdata[NIRQ-1:0]),
    .istat     (istat),
    .imask     (imask),
    .irq       (irq)
  );

  assign ecc_clr     = rst_busy;
  assign cfg_page512 = c_psz;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_psz      <= 1'b0;
      c_wide     <= 1'b0;
      c_rd_dly   <= '0;
      c_wr_dly   <= '0;
      rdy_q      <= 1'b1;
      rdy_qq     <= 1'b1;
      pg_rd_pend <= 1'b0;
      pg_wr_pend <= 1'b0;
      pg_rd_go   <= 1'b0;
      pg_wr_go   <= 1'b0;
      rst_busy   <= 1'b0;
      rst_cnt    <= '0;
    end else begin
      rdy_q  <= fl_rdy;
      rdy_qq <= rdy_q;
      if (wr_ctrl) begin
        c_psz    <= host_wdata[0];
        c_wide   <= host_wdata[1];
        c_rd_dly <= host_wdata[RD_LO +: DLY_W];
        c_wr_dly <= host_wdata[WR_LO +: DLY_W];
      end
      pg_rd_go <= wr_pg && host_wdata[0];
      pg_wr_go <= wr_pg && host_wdata[1];
      if (pg_done) begin
        pg_rd_pend <= 1'b0;
        pg_wr_pend <= 1'b0;
      end
      if (wr_pg && host_wdata[0]) pg_rd_pend <= 1'b1;
      if (wr_pg && host_wdata[1]) pg_wr_pend <= 1'b1;
      if (rst_busy) begin
        if (rst_cnt == '0) rst_busy <= 1'b0;
        else               rst_cnt  <= rst_cnt - 1'b1;
      end else if (wr_rst && host_wdata[0]) begin
        rst_busy <= 1'b1;
        rst_cnt  <= RST_LAST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      host_rdata <= '0;
      case (host_addr)
        A_CTRL: begin
          host_rdata[0] <= c_psz;
          host_rdata[1] <= c_wide;
          host_rdata[RD_LO +: DLY_W] <= c_rd_dly;
          host_rdata[WR_LO +: DLY_W] <= c_wr_dly;
        end
        A_STAT:  host_rdata[4:0] <= {wb_empty, pg_rd_pend, pg_wr_pend, wb_full, rdy_q};
        A_ISTAT: host_rdata[NIRQ-1:0] <= istat;
        A_IMASK: host_rdata[NIRQ-1:0] <= imask;
        A_RDATA: host_rdata[7:0] <= rd_byte;
        A_RST:   host_rdata[0] <= rst_busy;
        A_PGCTL: host_rdata[1:0] <= {pg_wr_pend, pg_rd_pend};
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nfc_host_chk.sv
module nfc_host_chk
  import nfc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            fl_we_n,
  input logic            fl_re_n,
  input logic            fl_ce_n,
  input logic            rdy_q,
  input logic            full,
  input logic            empty,
  input logic            pg_rd_go,
  input logic            pg_rd_pend,
  input logic            ecc_clr,
  input logic            host_wr,
  input logic [AW-1:0]   host_addr,
  input logic [HW-1:0]   host_wdata,
  input logic            irq,
  input logic [NIRQ-1:0] istat,
  input logic [NIRQ-1:0] imask
);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));

  assert_ce_in_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_re_n) |-> !fl_ce_n);

  assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_re_n) |-> $past(rdy_q));

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({full, empty}));

  assert_go_sets_pend_R11: assert property (@(posedge clk) disable iff (rst)
    pg_rd_go |-> pg_rd_pend);

  assert_clr_after_req_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(ecc_clr) |-> $past(host_wr && host_addr == A_RST && host_wdata[0]));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(istat & imask)));
endmodule

bind nfc_host_frontend nfc_host_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .fl_we_n    (fl_we_n),
  .fl_re_n    (fl_re_n),
  .fl_ce_n    (fl_ce_n),
  .rdy_q      (rdy_q),
  .full       (wb_full),
  .empty      (wb_empty),
  .pg_rd_go   (pg_rd_go),
  .pg_rd_pend (pg_rd_pend),
  .ecc_clr    (ecc_clr),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .irq        (irq),
  .istat      (istat),
  .imask      (imask)
);

// File: tb/nfc_host_frontend_tb.sv
`timescale 1ns/1ps
module nfc_host_frontend_tb;
  localparam int DEPTH = 4;
  localparam int RSTC  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq, fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_doe;
  logic [7:0]  fl_dout;
  logic [7:0]  fl_din = 8'h3C;
  logic        fl_rdy = 1'b1;
  logic        pg_done = 1'b0;
  logic        pg_rd_go, pg_wr_go, ecc_clr, cfg_page512;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  nfc_host_frontend #(.WB_DEPTH(DEPTH), .DLY_W(4), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dout(fl_dout), .fl_doe(fl_doe),
    .fl_din(fl_din), .fl_rdy(fl_rdy), .pg_done(pg_done), .pg_rd_go(pg_rd_go),
    .pg_wr_go(pg_wr_go), .ecc_clr(ecc_clr), .cfg_page512(cfg_page512)
  );

  // ---------------- reference model ----------------
  int q[$];
  int m_ph, m_cnt, m_isrd, m_cle, m_ale, m_we, m_re, m_ce, m_doe, m_dout;
  int m_rddone, m_cap, m_istat, m_mask, m_irq, m_ctrl, m_rdyq, m_rdyqq;
  int m_pgrp, m_pgwp, m_pgrgo, m_pgwgo, m_rbusy, m_rcnt, m_rdata;

  function automatic int mread(int a);
    case (a)
      0:  return m_ctrl;
      1:  return ((q.size() == 0) << 4) | (m_pgrp << 3) | (m_pgwp << 2) |
                 ((q.size() == DEPTH) << 1) | m_rdyq;
      2:  return m_istat;
      3:  return m_mask;
      8:  return m_cap;
      9:  return m_rbusy;
      10: return (m_pgwp << 1) | m_pgrp;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_ph = 0; m_cnt = 0; m_isrd = 0; m_cle = 0; m_ale = 0; m_we = 1; m_re = 1;
      m_ce = 1; m_doe = 0; m_dout = 0; m_rddone = 0; m_cap = 0; m_istat = 0;
      m_mask = 0; m_irq = 0; m_ctrl = 0; m_rdyq = 1; m_rdyqq = 1; m_pgrp = 0;
      m_pgwp = 0; m_pgrgo = 0; m_pgwgo = 0; m_rbusy = 0; m_rcnt = 0; m_rdata = 0;
    end else begin
      int rdd, wrd, kind, pop, full, done_new, drained, push, ovf, setv, clr, a, wd;
      a = host_addr; wd = host_wdata;
      rdd = (m_ctrl >> 4) & 15; wrd = (m_ctrl >> 8) & 15;
      full = (q.size() == DEPTH);
      if (host_rd) m_rdata = mread(a);
      pop = 0; done_new = 0;
      case (m_ph)
        0: if (q.size() != 0 && ((q[0] >> 8) != 3 || m_rdyq)) begin
             pop = 1; kind = q[0] >> 8; m_ph = 1;
             m_cnt = (kind == 3) ? rdd : wrd;
             m_we = (kind == 3); m_re = (kind != 3);
             m_cle = (kind == 0); m_ale = (kind == 1);
             m_dout = q[0] & 255; m_doe = (kind != 3); m_ce = 0; m_isrd = (kind == 3);
           end
        1: if (m_cnt == 0) begin
             m_we = 1; m_re = 1; m_ph = 2;
             if (m_isrd) begin m_cap = fl_din; done_new = 1; end
           end else m_cnt = m_cnt - 1;
        default: begin m_ph = 0; m_cle = 0; m_ale = 0; m_doe = 0; m_ce = 1; end
      endcase
      drained = pop && full;
      push = host_wr && a >= 4 && a <= 7;
      ovf = push && full;
      if (pop) void'(q.pop_front());
      if (push && !full) q.push_back(((a - 4) << 8) | ((a == 7) ? 0 : (wd & 255)));
      setv = (m_rdyq && !m_rdyqq) | (ovf << 1) | (drained << 2) | (m_rddone << 3) |
             ((pg_done && m_pgwp) << 4);
      clr = (host_wr && a == 2) ? (wd & 31) : 0;
      m_irq = ((m_istat & m_mask) != 0);
      m_istat = (m_istat & ~clr & 31) | setv;
      if (host_wr && a == 3) m_mask = wd & 31;
      m_rddone = done_new;
      m_rdyqq = m_rdyq; m_rdyq = fl_rdy;
      m_pgrgo = host_wr && a == 10 && wd[0];
      m_pgwgo = host_wr && a == 10 && wd[1];
      if (pg_done) begin m_pgrp = 0; m_pgwp = 0; end
      if (m_pgrgo) m_pgrp = 1;
      if (m_pgwgo) m_pgwp = 1;
      if (m_rbusy) begin
        if (m_rcnt == 0) m_rbusy = 0; else m_rcnt = m_rcnt - 1;
      end else if (host_wr && a == 9 && wd[0]) begin
        m_rbusy = 1; m_rcnt = RSTC - 1;
      end
      if (host_wr && a == 0) m_ctrl = wd & 16'h0FF3;
    end
  end

  task automatic cmp(string tag, string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, one time unit after each rising edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (started) begin
      cmp("R14", "host_rdata", host_rdata, m_rdata);
      cmp("R4", "fl_we_n", fl_we_n, m_we);
      cmp("R5", "fl_re_n", fl_re_n, m_re);
      cmp("R4", "fl_cle", fl_cle, m_cle);
      cmp("R4", "fl_ale", fl_ale, m_ale);
      cmp("R4", "fl_ce_n", fl_ce_n, m_ce);
      cmp("R4", "fl_doe", fl_doe, m_doe);
      cmp("R4", "fl_dout", fl_dout, m_dout);
      cmp("R10", "irq", irq, m_irq);
      cmp("R11", "pg_rd_go", pg_rd_go, m_pgrgo);
      cmp("R11", "pg_wr_go", pg_wr_go, m_pgwgo);
      cmp("R12", "ecc_clr", ecc_clr, m_rbusy);
      cmp("R13", "cfg_page512", cfg_page512, m_ctrl & 1);
    end
  end

  // ---------------- stimulus ----------------
  task automatic hwr(int a, int d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'(a); host_wdata = 16'(d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rdchk(int a, int msk, int exp, string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 4'(a);
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    cmp(tag, "register read", host_rdata & msk, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1;
    // R1 reset state
    rdchk(1, 16'h1F, 16'h11, "R1");
    rdchk(2, 16'h1F, 0, "R1");
    cmp("R1", "strobes idle", {fl_ce_n, fl_we_n, fl_re_n}, 3'b111);
    // R13 control fields
    hwr(0, 16'h0211);
    rdchk(0, 16'hFFFF, 16'h0211, "R13");
    cmp("R13", "cfg_page512", cfg_page512, 1);
    // R4 command, address, data cycles
    hwr(4, 8'h70); hwr(5, 8'h12); hwr(6, 8'hA5);
    idle(20);
    rdchk(1, 16'h10, 16'h10, "R2");
    // R5 single-byte read
    hwr(7, 16'hBEEF);
    idle(10);
    rdchk(8, 16'hFF, 8'h3C, "R5");
    rdchk(2, 16'h08, 16'h08, "R5");
    hwr(2, 16'h08);
    rdchk(2, 16'h08, 0, "R9");
    // R2/R3/R8 fill and overflow with long write strobes
    hwr(0, 16'h0F11);
    for (int i = 0; i < 7; i++) hwr(6, 8'h10 + i);
    rdchk(1, 16'h12, 16'h02, "R2");
    rdchk(2, 16'h02, 16'h02, "R3");
    idle(110);
    rdchk(2, 16'h04, 16'h04, "R8");
    rdchk(1, 16'h10, 16'h10, "R3");
    hwr(2, 16'h1F);
    rdchk(2, 16'h1F, 0, "R9");
    hwr(0, 16'h0211);
    // R6/R7 read waits for ready
    @(negedge clk) fl_rdy = 1'b0;
    idle(3);
    hwr(7, 0); hwr(4, 8'h55);
    idle(10);
    rdchk(1, 16'h11, 16'h00, "R7");
    cmp("R6", "fl_re_n while busy", fl_re_n, 1);
    @(negedge clk) begin fl_din = 8'h96; fl_rdy = 1'b1; end
    idle(15);
    rdchk(8, 16'hFF, 8'h96, "R6");
    rdchk(2, 16'h01, 16'h01, "R7");
    // R9/R10 mask and write-one-to-clear
    hwr(3, 16'h08);
    idle(2);
    cmp("R10", "irq masked set", irq, 1);
    hwr(2, 16'h01);
    rdchk(2, 16'h09, 16'h08, "R9");
    hwr(2, 16'h08);
    idle(2);
    cmp("R10", "irq cleared", irq, 0);
    // R11 page strobes
    hwr(10, 2);
    rdchk(1, 16'h0C, 16'h04, "R11");
    @(negedge clk) pg_done = 1'b1;
    @(negedge clk) pg_done = 1'b0;
    rdchk(1, 16'h0C, 0, "R11");
    rdchk(2, 16'h10, 16'h10, "R11");
    hwr(10, 1);
    rdchk(1, 16'h0C, 16'h08, "R11");
    @(negedge clk) pg_done = 1'b1;
    @(negedge clk) pg_done = 1'b0;
    // R12 self-clearing reset
    hwr(9, 1);
    rdchk(9, 1, 1, "R12");
    idle(12);
    rdchk(9, 1, 0, "R12");
    // R14 reads without side effects
    rdchk(2, 16'h1F, 16'h10, "R14");
    rdchk(2, 16'h1F, 16'h10, "R14");
    idle(5);
    finish_run();
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule